// File: doc/BRIEF.md
# Retriggerable Resettable One-Shot

This block is a clocked monostable pulse generator. It watches two trigger lines. A rising edge on `a_i` while `b_i` is high starts an output pulse. A falling edge on `b_i` while `a_i` is low also starts one. The pulse lasts a programmable number of clock cycles, taken from `width_i` at the moment of the trigger. The block drives a true output and its complement. Both trigger lines pass through synchronisers, so they may be asynchronous to the clock.

In retriggerable mode, each new qualified trigger restarts the full count. In one-shot mode, triggers that arrive while the pulse is running are ignored. A functional clear input forces the pulse off at once and disarms the edge detectors. Neither leaving the clear nor leaving the system reset can fire a pulse. A dual part is built from two instances.

Top module: `retrig_oneshot`

## Requirements
- R1: `qn_o` is always the complement of `q_o`. While `rst_ni` is low, `q_o` is 0 and `qn_o` is 1.
- R2: A rise of `a_i` from 0 to 1 while `b_i` is 1 starts a pulse. `q_o` goes high after the third rising clock edge that follows the change on the input.
- R3: A fall of `b_i` from 1 to 0 while `a_i` is 0 starts a pulse, with the same latency as R2.
- R4: These events do not start a pulse:
  - a rise of `a_i` while `b_i` is 0;
  - a fall of `b_i` while `a_i` is 1;
  - a rise of `a_i` and a fall of `b_i` in the same cycle.
- R5: A started pulse keeps `q_o` high for exactly the value of `width_i` seen in the trigger cycle. Changing `width_i` while the pulse runs has no effect on that pulse.
- R6: A `width_i` of 0 produces no pulse. A `width_i` of 1 produces a pulse of a single cycle.
- R7: With `retrig_i` = 1, a qualified trigger during a pulse reloads the count from that trigger. This also holds when the trigger falls on the last high cycle of the pulse, which keeps `q_o` high without a gap. A reload with a width of 0 ends the pulse.
- R8: With `retrig_i` = 0, a qualified trigger evaluated while `q_o` is high is discarded. This includes a trigger on the last high cycle, so `q_o` falls as scheduled.
- R9: While `clr_ni` is 0:
  - `q_o` is 0 and `qn_o` is 1 in the same cycle;
  - the running count is cleared;
  - triggers are discarded.
- R10: Releasing `clr_ni` or `rst_ni` never starts a pulse. Input edges applied while `clr_ni` is 0, or in the cycle it returns to 1, are discarded. After `rst_ni` is released, the input levels present at release are not taken as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| clr_ni | input | 1 | Functional clear, active low, synchronous to `clk_i` |
| a_i | input | 1 | Rising-edge trigger line, asynchronous |
| b_i | input | 1 | Falling-edge trigger line, asynchronous |
| retrig_i | input | 1 | 1 = retriggerable, 0 = one-shot |
| width_i | input | CNT_W | Pulse length in clock cycles |
| q_o | output | 1 | Pulse output |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
Two functions can fall in the same clock edge:
- a new trigger, and the final decrement that would end a pulse;
- a trigger, and an active clear.

The first case is provoked by trains of triggers spaced exactly one pulse width apart, and also spaced closer than that, in both modes. Retriggerable mode must give an unbroken high output, and one-shot mode must give a gap of exactly one pulse width. For the second case, the bench moves edges into and out of the clear window, including an edge driven together with the release of the clear. A cycle-accurate reference model judges every cycle, and a randomised phase mixes all input combinations, clear and mode.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_RETRIG  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
module os_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/os_trig_qual.sv
`timescale 1ns/1ps
module os_trig_qual
  import oneshot_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic a_s_i,
  input  logic b_s_i,
  input  logic retrig_i,
  input  logic busy_i,
  output logic fire_o
);
  // edge register plus sync chain must refill before edges are trusted
  localparam int unsigned ARM_CYCLES = SYNC_STAGES + 1;
  localparam int unsigned WARM_W     = $clog2(ARM_CYCLES + 1);

  logic              a_q, b_q;
  logic [WARM_W-1:0] warm_q;
  logic              armed, rise_a, fall_b, may_fire;
  trig_mode_e        mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      warm_q <= '0;
    end else begin
      a_q <= a_s_i;
      b_q <= b_s_i;
      if (!clr_ni)     warm_q <= '0;
      else if (!armed) warm_q <= warm_q + 1'b1;
    end
  end

  assign armed    = (warm_q == WARM_W'(ARM_CYCLES));
  assign rise_a   = a_s_i & ~a_q & b_s_i;
  assign fall_b   = ~b_s_i & b_q & ~a_s_i;
  assign mode     = trig_mode_e'(retrig_i);
  assign may_fire = (mode == MODE_RETRIG) | ~busy_i;
  assign fire_o   = (rise_a | fall_b) & armed & clr_ni & may_fire;
endmodule

// File: rtl/os_pulse_timer.sv
`timescale 1ns/1ps
module os_pulse_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  // clear beats load, load beats decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!clr_ni) cnt_q <= '0;
    else if (load_i)  cnt_q <= width_i;
    else if (busy_o)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = |cnt_q;
endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
module retrig_oneshot #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             retrig_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             q_o,
  output logic             qn_o
);
  logic a_s, b_s, fire, busy;

  os_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(a_i), .q_o(a_s)
  );
  os_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(b_s)
  );

  os_trig_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_ni  (clr_ni),
    .a_s_i   (a_s),
    .b_s_i   (b_s),
    .retrig_i(retrig_i),
    .busy_i  (busy),
    .fire_o  (fire)
  );

  os_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .load_i (fire),
    .width_i(width_i),
    .busy_o (busy)
  );

  // clear acts on the output without waiting for a clock edge
  assign q_o  = busy & clr_ni;
  assign qn_o = ~q_o;
endmodule

// File: rtl/retrig_oneshot_chk.sv
`timescale 1ns/1ps
module retrig_oneshot_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             retrig_i,
  input logic [CNT_W-1:0] width_i,
  input logic             fire_i,
  input logic             busy_i,
  input logic             q_o,
  input logic             qn_o
);
  a_r1_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qn_o == ~q_o);

  a_r9_clear_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (!q_o && qn_o));

  a_r9_no_fire_in_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> !fire_i);

  a_r8_oneshot_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retrig_i && busy_i) |-> !fire_i);

  a_r5_load_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (busy_i == ($past(width_i) != '0)));

  a_r10_no_start_without_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !fire_i) |=> !busy_i);
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_ni  (clr_ni),
  .retrig_i(retrig_i),
  .width_i (width_i),
  .fire_i  (fire),
  .busy_i  (busy),
  .q_o     (q_o),
  .qn_o    (qn_o)
);

// File: tb/tb_retrig_oneshot.sv
`timescale 1ns/1ps
module tb_retrig_oneshot;
  localparam int CNT_W = 16;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic             rst_ni, clr_ni, a_i, b_i, retrig_i;
  logic [CNT_W-1:0] width_i;
  logic             q_o, qn_o;

  retrig_oneshot #(.SYNC_STAGES(2), .CNT_W(CNT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .a_i(a_i), .b_i(b_i),
    .retrig_i(retrig_i), .width_i(width_i), .q_o(q_o), .qn_o(qn_o)
  );

  typedef struct { bit exp; string tag; } item_t;
  item_t sb[$];
  int    checks = 0, errors = 0;
  bit    done = 0;

  // reference model, built from R2, R3, R5 to R10
  bit          m_s1a, m_s2a, m_pa, m_s1b, m_s2b, m_pb;
  int          m_warm;
  int unsigned m_cnt;

  task automatic model_edge();
    bit rise, fall, fire;
    if (!rst_ni) begin
      {m_s1a, m_s2a, m_pa, m_s1b, m_s2b, m_pb} = '0;
      m_warm = 0;
      m_cnt  = 0;
      return;
    end
    rise = m_s2a && !m_pa && m_s2b;
    fall = !m_s2b && m_pb && !m_s2a;
    fire = (rise || fall) && (m_warm == 3) && clr_ni && (retrig_i || m_cnt == 0);
    if (!clr_ni)         m_cnt = 0;
    else if (fire)       m_cnt = width_i;
    else if (m_cnt != 0) m_cnt = m_cnt - 1;
    if (!clr_ni)         m_warm = 0;
    else if (m_warm < 3) m_warm = m_warm + 1;
    m_pa = m_s2a; m_s2a = m_s1a; m_s1a = a_i;
    m_pb = m_s2b; m_s2b = m_s1b; m_s1b = b_i;
  endtask

  // driver: applies levels for n cycles and pushes the expected output
  task automatic step(bit a, bit b, bit clr, int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      model_edge();
      #1;
      a_i = a; b_i = b; clr_ni = clr;
      sb.push_back('{exp: (m_cnt != 0) && clr && rst_ni, tag: tag});
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (q_o !== it.exp || qn_o !== !it.exp) begin
          errors++;
          $display("FAIL %s: q_o=%b qn_o=%b expected q_o=%b qn_o=%b at %0t",
                   it.tag, q_o, qn_o, it.exp, !it.exp, $time);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run still active, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; clr_ni = 1'b1; a_i = 1'b1; b_i = 1'b1;
    retrig_i = 1'b1; width_i = 16'd5;
    #2;
    checks++;
    if (q_o !== 1'b0 || qn_o !== 1'b1) begin
      errors++;
      $display("FAIL R1: q_o=%b qn_o=%b expected q_o=0 qn_o=1", q_o, qn_o);
    end
    step(1, 1, 1, 3, "R1");
    rst_ni = 1'b1;
    step(1, 1, 1, 8, "R10 reset release");
    // R2 rising edge on a with b high
    step(0, 1, 1, 4, "R2"); step(1, 1, 1, 10, "R2");
    // R4 non-qualifying edges
    step(1, 0, 1, 4, "R4"); step(0, 0, 1, 3, "R4"); step(1, 0, 1, 6, "R4");
    step(1, 1, 1, 4, "R4"); step(1, 0, 1, 6, "R4");
    step(0, 1, 1, 4, "R4"); step(1, 0, 1, 6, "R4");
    // R3 falling edge on b with a low
    step(0, 1, 1, 4, "R3"); step(0, 0, 1, 10, "R3");
    // R6 widths 0 and 1
    width_i = 16'd0; step(0, 1, 1, 4, "R6"); step(1, 1, 1, 8, "R6");
    width_i = 16'd1; step(0, 1, 1, 3, "R6"); step(1, 1, 1, 6, "R6");
    // R5 width latched at trigger
    width_i = 16'd6; step(0, 1, 1, 3, "R5"); step(1, 1, 1, 4, "R5");
    width_i = 16'd2; step(1, 1, 1, 8, "R5");
    // R7 retrigger, spacing equal to width (last cycle) and shorter
    retrig_i = 1'b1; width_i = 16'd4;
    for (int k = 0; k < 5; k++) begin step(0, 1, 1, 2, "R7"); step(1, 1, 1, 2, "R7"); end
    for (int k = 0; k < 6; k++) begin step(0, 1, 1, 1, "R7"); step(1, 1, 1, 1, "R7"); end
    step(0, 1, 1, 10, "R7");
    // R8 one-shot mode, same trains
    retrig_i = 1'b0;
    for (int k = 0; k < 5; k++) begin step(1, 1, 1, 2, "R8"); step(0, 1, 1, 2, "R8"); end
    for (int k = 0; k < 6; k++) begin step(1, 1, 1, 1, "R8"); step(0, 1, 1, 1, "R8"); end
    step(0, 1, 1, 10, "R8");
    // R9 clear during a pulse, edge inside the clear window
    retrig_i = 1'b1; width_i = 16'd8;
    step(0, 1, 1, 3, "R9"); step(1, 1, 1, 3, "R9"); step(1, 1, 0, 2, "R9");
    step(0, 1, 0, 2, "R9"); step(1, 1, 0, 3, "R9"); step(1, 1, 1, 8, "R9");
    // R10 edge driven together with clear release, then a late edge
    step(0, 1, 0, 4, "R10"); step(1, 1, 1, 8, "R10");
    step(0, 1, 1, 1, "R10"); step(1, 1, 1, 12, "R10");
    // mixed phase over all input, clear and mode combinations
    for (int k = 0; k < 600; k++) begin
      if (k % 40 == 0) retrig_i = $urandom_range(0, 1);
      if (k % 7 == 0)  width_i = CNT_W'($urandom_range(0, 6));
      step($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 15) != 0),
           1, "R2 R3 R7 R8 R9 mixed");
    end
    step(0, 1, 1, 12, "R5 drain");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule